// File: doc/BRIEF.md
# Frequency-Switch Watchdog with Staged Recovery

This block guards a change of the clock-generator frequency selection. Software loads a target frequency code, a fall-back code and a timeout in whole seconds, then sets the enable bit. When the new frequency works, software clears the enable bit before the interval runs out. When the system hangs, the timer expires. The block then pulls the active-low system reset low for half a second and moves the frequency selection one recovery stage further.

The first expiry moves the selection from the target code to the fall-back code. A second expiry moves it to the code on the external strap pins, and it stays there until power-on reset. An internal prescaler turns the system clock into one-second ticks. The parameter `CLK_HZ` gives the clock cycles per second, and half of it sets the length of the reset pulse. The enable bit is held inside the block, takes software writes through a write strobe, and clears itself when a reset pulse starts. All pins are plain control and status signals. There is no streaming interface and no back-pressure.

Top module: `wdf_supervisor`

## Requirements
- R1: While `por_n` is low and just after it rises, `sys_rst_n` is 1, `wd_active` is 0 and `freq_sel` equals `strap_code`.
- R2: A write with `en_val`=1 while the timer is idle arms it and restarts the one-second prescaler and the seconds count. With no disarm, `sys_rst_n` first reads 0 after the clock edge `CLK_HZ*ivl_sec` cycles after the arming edge.
- R3: An `ivl_sec` of 0 expires on the first one-second tick, `CLK_HZ` cycles after the arming edge.
- R4: A write with `en_val`=0 before expiry stops the timer and produces no reset. A later arm counts from zero again.
- R5: On expiry `sys_rst_n` stays low for exactly `CLK_HZ/2` cycles, then returns to 1.
- R6: `wd_active` reads 0 from the expiry edge on. Enable writes made while the reset pulse is low are ignored.
- R7: In the normal stage, `freq_sel` equals `strap_code` until the first arm after power-on, and equals `target_code` from the arming edge on.
- R8: The first expiry in the normal stage switches `freq_sel` to `fallback_code`.
- R9: An expiry in the fall-back stage switches `freq_sel` to `strap_code`. Later expiries keep it on `strap_code`.
- R10: Power-on reset returns the block to the normal stage from any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` cycles per second |
| por_n | input | 1 | Active-low power-on reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| ivl_sec | input | 6 | Timeout in seconds, 0 to 63 |
| target_code | input | 5 | Frequency code to try |
| fallback_code | input | 5 | Frequency code used after the first expiry |
| strap_code | input | 5 | Code from the external strap pins |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| freq_sel | output | 5 | Frequency selection sent to the clock generator |
| wd_active | output | 1 | Current value of the enable bit |

## Verification
The hardest stage to reach from the pins is the strap stage, together with its stickiness. It needs two full expiries in a row, each followed by a complete half-second reset pulse, and a re-arm after each pulse because the enable bit clears itself. The bench uses a small `CLK_HZ` of 20, so one second is 20 cycles. It chains arm, expire and re-arm three times, then sweeps every interval from 0 to 63 from a fresh power-on. For each interval it measures the exact cycle of expiry and the pulse length. It also tries an arm during the pulse, and a disarm followed by a re-arm partway through an interval.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_FALLBACK = 2'd1,
    ST_STRAP    = 2'd2
  } stage_t;
endpackage

// File: rtl/wdf_prescale.sv
module wdf_prescale #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= LAST);
endmodule

// File: rtl/wdf_timer.sv
module wdf_timer #(
  parameter int CLK_HZ = 100_000_000,
  parameter int IVL_W  = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic [IVL_W-1:0] ivl_sec,
  input  logic             tick,
  output logic             arm_evt,
  output logic             expire,
  output logic             active,
  output logic             sys_rst_n
);
  localparam int HALF = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
  localparam int PW   = $clog2(HALF + 1);
  localparam logic [PW-1:0] HALF_V = PW'(HALF);

  logic [IVL_W-1:0] secs;
  logic [IVL_W:0]   next_secs;
  logic [PW-1:0]    pcnt;
  logic             in_pulse;

  assign in_pulse  = (pcnt != '0);
  assign arm_evt   = en_wr && en_val && !active && !in_pulse;
  assign next_secs = {1'b0, secs} + 1'b1;
  assign expire    = active && tick && (next_secs >= {1'b0, ivl_sec});
  assign sys_rst_n = !in_pulse;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active <= 1'b0;
      pcnt   <= '0;
    end else if (expire) begin
      active <= 1'b0;
      pcnt   <= HALF_V;
    end else begin
      if (in_pulse)
        pcnt <= pcnt - 1'b1;
      else if (en_wr)
        active <= en_val;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              secs <= '0;
    else if (arm_evt)        secs <= '0;
    else if (active && tick) secs <= next_secs[IVL_W-1:0];
  end

  a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!por_n)
    pcnt <= HALF_V);
  a_r6_idle_in_pulse: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> !active);
  a_r5_fall_from_armed: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst_n) |-> $past(active));
  a_r4_disarm_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (!active && sys_rst_n && !en_wr) |=> sys_rst_n);
endmodule

// File: rtl/wdf_stage.sv
module wdf_stage
  import wdf_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              arm_evt,
  input  logic              expire,
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] fallback_code,
  input  logic [CODE_W-1:0] strap_code,
  output logic [CODE_W-1:0] freq_sel
);
  stage_t stage;
  logic   committed;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stage     <= ST_NORMAL;
      committed <= 1'b0;
    end else begin
      if (arm_evt) committed <= 1'b1;
      if (expire) begin
        unique case (stage)
          ST_NORMAL:   stage <= ST_FALLBACK;
          ST_FALLBACK: stage <= ST_STRAP;
          default:     stage <= ST_STRAP;
        endcase
      end
    end
  end

  always_comb begin
    unique case (stage)
      ST_NORMAL:   freq_sel = committed ? target_code : strap_code;
      ST_FALLBACK: freq_sel = fallback_code;
      default:     freq_sel = strap_code;
    endcase
  end

  a_r9_strap_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (stage == ST_STRAP) |=> (stage == ST_STRAP));
  a_r8_first_step: assert property (@(posedge clk) disable iff (!por_n)
    (expire && stage == ST_NORMAL) |=> (stage == ST_FALLBACK));
  a_r9_second_step: assert property (@(posedge clk) disable iff (!por_n)
    (expire && stage == ST_FALLBACK) |=> (stage == ST_STRAP));
  a_r7_commit_sticky: assert property (@(posedge clk) disable iff (!por_n)
    committed |=> committed);
endmodule

// File: rtl/wdf_supervisor.sv
module wdf_supervisor #(
  parameter int CLK_HZ = 100_000_000,
  parameter int IVL_W  = 6,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic [IVL_W-1:0]  ivl_sec,
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] fallback_code,
  input  logic [CODE_W-1:0] strap_code,
  output logic              sys_rst_n,
  output logic [CODE_W-1:0] freq_sel,
  output logic              wd_active
);
  logic tick;
  logic arm_evt;
  logic expire;

  wdf_prescale #(.CLK_HZ(CLK_HZ)) u_presc (
    .clk   (clk),
    .por_n (por_n),
    .clr   (arm_evt),
    .tick  (tick)
  );

  wdf_timer #(.CLK_HZ(CLK_HZ), .IVL_W(IVL_W)) u_timer (
    .clk       (clk),
    .por_n     (por_n),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .ivl_sec   (ivl_sec),
    .tick      (tick),
    .arm_evt   (arm_evt),
    .expire    (expire),
    .active    (wd_active),
    .sys_rst_n (sys_rst_n)
  );

  wdf_stage #(.CODE_W(CODE_W)) u_stage (
    .clk           (clk),
    .por_n         (por_n),
    .arm_evt       (arm_evt),
    .expire        (expire),
    .target_code   (target_code),
    .fallback_code (fallback_code),
    .strap_code    (strap_code),
    .freq_sel      (freq_sel)
  );

  a_r6_clear_on_fall: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst_n) |-> !wd_active);
endmodule

// File: tb/wdf_supervisor_test.sv
module wdf_supervisor_test;
  localparam int HZ   = 20;
  localparam int HALF = HZ / 2;
  localparam logic [4:0] STRAP = 5'h03;
  localparam logic [4:0] TGT   = 5'h11;
  localparam logic [4:0] FB    = 5'h0A;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       en_wr = 1'b0;
  logic       en_val = 1'b0;
  logic [5:0] ivl_sec = 6'd0;
  logic [4:0] target_code = TGT;
  logic [4:0] fallback_code = FB;
  logic [4:0] strap_code = STRAP;
  logic       sys_rst_n;
  logic [4:0] freq_sel;
  logic       wd_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wdf_supervisor #(.CLK_HZ(HZ)) uut (
    .clk(clk), .por_n(por_n), .en_wr(en_wr), .en_val(en_val),
    .ivl_sec(ivl_sec), .target_code(target_code),
    .fallback_code(fallback_code), .strap_code(strap_code),
    .sys_rst_n(sys_rst_n), .freq_sel(freq_sel), .wd_active(wd_active)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    en_wr = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_en(input bit v);
    en_wr  = 1'b1;
    en_val = v;
    @(negedge clk);
    en_wr  = 1'b0;
  endtask

  // Arms from a negedge; returns the cycle count to the fall and the low length.
  task automatic run_expire(input int ivl, output int fall_at, output int low_len);
    ivl_sec = 6'(ivl);
    write_en(1'b1);
    fall_at = 0;
    while (sys_rst_n && fall_at < 5000) begin
      fall_at = fall_at + 1;
      @(negedge clk);
    end
    low_len = 0;
    while (!sys_rst_n && low_len < 5000) begin
      low_len = low_len + 1;
      @(negedge clk);
    end
  endtask

  initial begin
    int fall_at;
    int low_len;
    int lows;

    // R1: reset state
    @(negedge clk);
    chk(sys_rst_n == 1'b1, "R1 rst_n during por", sys_rst_n, 1);
    chk(freq_sel == STRAP, "R1 freq during por", freq_sel, STRAP);
    do_por();
    chk(wd_active == 1'b0, "R1 active after por", wd_active, 0);
    chk(freq_sel == STRAP, "R1 freq after por", freq_sel, STRAP);

    // R7 + R4: arm, disarm early, no reset
    ivl_sec = 6'd2;
    write_en(1'b1);
    chk(wd_active == 1'b1, "R7 armed", wd_active, 1);
    chk(freq_sel == TGT, "R7 target selected", freq_sel, TGT);
    repeat (30) @(negedge clk);
    write_en(1'b0);
    lows = 0;
    for (int i = 0; i < 120; i++) begin
      if (!sys_rst_n) lows = lows + 1;
      @(negedge clk);
    end
    chk(lows == 0, "R4 no reset after disarm", lows, 0);
    chk(freq_sel == TGT, "R4 target kept", freq_sel, TGT);

    // R4 + R2: re-arm restarts count
    write_en(1'b1);
    repeat (30) @(negedge clk);
    write_en(1'b0);
    run_expire(2, fall_at, low_len);
    chk(fall_at == 2 * HZ, "R2 R4 restart from rearm", fall_at, 2 * HZ);
    chk(low_len == HALF, "R5 pulse length", low_len, HALF);
    chk(wd_active == 1'b0, "R6 enable cleared", wd_active, 0);
    chk(freq_sel == FB, "R8 fallback code", freq_sel, FB);

    // R6: write during the pulse is ignored
    ivl_sec = 6'd1;
    write_en(1'b1);
    fall_at = 0;
    while (sys_rst_n && fall_at < 5000) begin
      fall_at = fall_at + 1;
      @(negedge clk);
    end
    chk(fall_at == HZ, "R2 fallback stage timing", fall_at, HZ);
    write_en(1'b1);
    repeat (HALF + 2) @(negedge clk);
    chk(wd_active == 1'b0, "R6 write in pulse ignored", wd_active, 0);
    chk(sys_rst_n == 1'b1, "R6 no extra pulse", sys_rst_n, 1);
    chk(freq_sel == STRAP, "R9 strap after second", freq_sel, STRAP);

    // R9: third expiry stays on strap
    run_expire(0, fall_at, low_len);
    chk(fall_at == HZ, "R3 zero interval", fall_at, HZ);
    chk(freq_sel == STRAP, "R9 strap sticky", freq_sel, STRAP);

    // R10: por returns to normal
    do_por();
    chk(freq_sel == STRAP, "R10 uncommitted after por", freq_sel, STRAP);
    ivl_sec = 6'd5;
    write_en(1'b1);
    chk(freq_sel == TGT, "R10 normal stage", freq_sel, TGT);
    write_en(1'b0);

    // Sweep every interval from a fresh power-on
    for (int v = 0; v < 64; v++) begin
      do_por();
      run_expire(v, fall_at, low_len);
      chk(fall_at == HZ * ((v == 0) ? 1 : v), "R2 R3 sweep expiry", fall_at,
          HZ * ((v == 0) ? 1 : v));
      chk(low_len == HALF, "R5 sweep pulse", low_len, HALF);
      chk(freq_sel == FB, "R8 sweep fallback", freq_sel, FB);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule